// File: doc/BRIEF.md
# Time-Multiplexed Spike and Learning-Pulse Synapse Driver

This block drives the two ends of one synapse in a spike-timing learning array. Time on the synapse is cut into repeating frames of five equal slots. The first slot carries the ordinary spike from the input-side (pre) neuron to the output-side (post) neuron. The other four slots carry learning information as pulse widths. Two slots send the pre neuron's potentiation timing forward. Two slots send the post neuron's depression timing backward. Each learning quantity uses a pair of slots: in the first slot of the pair the line is high for the width, and in the second slot the waveform is inverted.

Each neuron keeps a decaying timing trace. The trace is loaded to its maximum in the frame in which that neuron's spike is emitted, and it falls by one per frame after that. A receiving side measures the high time of the incoming plus slot. It reports that width as a weight update only when its own neuron fired in the same frame. A post spike that closely follows a pre spike therefore yields potentiation, and the reverse order yields depression.

Top module: `stdp_tdm_driver`

## Requirements
- R1: `slot_idx` steps through 0,1,2,3,4 and then repeats. Each value lasts SLOT_LEN clock cycles (default 16), and the sequence starts at slot 0, cycle 0 after reset.
- R2: A spike on `pre_spike` during a frame is held and emitted in the next frame as a single-cycle high on `pre_line` in cycle 0 of slot 0. `comm_spike` is high in exactly that cycle. `post_spike` never appears on either line in slot 0.
- R3: Let W be the pre trace saturated to SLOT_LEN. In slot 1, `pre_line` is high for the first W cycles and low for the rest. In slot 2 it is low for the first W cycles and high for the rest. In slots 3 and 4 it is low.
- R4: `post_line` behaves in the same way in slots 3 and 4, using the post trace. It is low in slots 0 to 2.
- R5: A trace equals TRACE_MAX (default 15) in the frame in which its neuron's spike is emitted. It then drops by 1 per frame and stops at 0.
- R6: At the end of slot 2, `ltp_upd` becomes the high-cycle count measured on `pre_line` in slot 1 if the post neuron fired this frame, and 0 otherwise. At all other times it holds its value.
- R7: At the end of slot 4, `ltd_upd` becomes the high-cycle count measured on `post_line` in slot 3 if the pre neuron fired this frame, and 0 otherwise. At all other times it holds its value.
- R8: While `rst_n` is low (synchronous), the slot counter, both traces and pending spikes are cleared. Both lines are low, both updates are 0, and `slot_idx` is 0.
- R9: Any number of spikes on one input within one frame, including one in the frame's last cycle, produce exactly one emission in the next frame.
- R10: Over each plus/minus slot pair, a line is high for exactly SLOT_LEN cycles in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pre_spike | input | 1 | Spike from the pre neuron |
| post_spike | input | 1 | Spike from the post neuron |
| pre_line | output | 1 | Pre-to-post synapse line (spike and potentiation pulses) |
| post_line | output | 1 | Post-to-pre synapse line (depression pulses) |
| comm_spike | output | 1 | Spike received by the post neuron in slot 0 |
| slot_idx | output | 3 | Current slot of the frame |
| ltp_upd | output | clog2(SLOT_LEN+1) | Potentiation magnitude from the last frame |
| ltd_upd | output | clog2(SLOT_LEN+1) | Depression magnitude from the last frame |

## Verification
A trace that is loaded or decayed wrongly shows up within one frame, as a wrong pulse width in the next learning slot on the line. It then shows up again in the update value reported at the end of that slot pair. A lost or duplicated pending spike shows up at the next frame's first cycle, where the slot-0 pulse is either missing or present when it should not be. A slot counter that slips shows up at once in `slot_idx`, and a fired flag that is wrong shows up as a zero or nonzero update at the slot-pair boundary. A cycle-accurate model in the bench compares every output on every clock, so any of these faults is reported in the cycle where it first reaches a port.

// File: rtl/stdp_pkg.sv
// Shared slot encoding for the synapse driver.
// Assumes a fixed five-slot frame; the slot order is behaviour.
package stdp_pkg;
    localparam int unsigned NUM_SLOTS = 5;

    typedef enum logic [2:0] {
        SLOT_COMM    = 3'd0,
        SLOT_LTP_POS = 3'd1,
        SLOT_LTP_NEG = 3'd2,
        SLOT_LTD_POS = 3'd3,
        SLOT_LTD_NEG = 3'd4
    } slot_e;
endpackage

// File: rtl/stdp_frame_timer.sv
// Frame timer: counts cycles within a slot and slots within a frame.
// Assumes SLOT_LEN >= 2. It flags the last cycle of each slot and of the frame.
module stdp_frame_timer
    import stdp_pkg::*;
#(
    parameter int unsigned SLOT_LEN = 16,
    parameter int unsigned CW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    output slot_e         slot_o,
    output logic [CW-1:0] cyc_o,
    output logic          slot_end_o,
    output logic          frame_end_o
);
    slot_e         slot_q;
    logic [CW-1:0] cyc_q;

    // Advance the cycle counter, then the slot at the end of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_COMM;
            cyc_q  <= '0;
        end else if (cyc_q == CW'(SLOT_LEN - 1)) begin
            cyc_q  <= '0;
            slot_q <= (slot_q == SLOT_LTD_NEG) ? SLOT_COMM : slot_e'(3'(slot_q) + 3'd1);
        end else begin
            cyc_q <= cyc_q + CW'(1);
        end
    end

    // Decode the end-of-slot and end-of-frame flags.
    always_comb begin
        slot_end_o  = (cyc_q == CW'(SLOT_LEN - 1));
        frame_end_o = slot_end_o && (slot_q == SLOT_LTD_NEG);
    end

    assign slot_o = slot_q;
    assign cyc_o  = cyc_q;
endmodule

// File: rtl/stdp_trace_unit.sv
// Per-neuron timing state: a pending spike, a fired flag for the current
// frame, and a trace that decays once per frame.
// Assumes frame_end_i pulses on the last cycle of each frame.
// The width output is the trace saturated to SLOT_LEN.
module stdp_trace_unit #(
    parameter int unsigned SLOT_LEN  = 16,
    parameter int unsigned TRACE_MAX = 15,
    parameter int unsigned TW        = 4,
    parameter int unsigned WW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spike_i,
    input  logic          frame_end_i,
    output logic          fired_o,
    output logic [WW-1:0] width_o
);
    logic          pend_q;
    logic          fired_q;
    logic [TW-1:0] trace_q;
    logic          fire_now;

    assign fire_now = pend_q | spike_i;

    // Latch spikes; at the frame boundary, emit them and load or decay the trace.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            fired_q <= 1'b0;
            trace_q <= '0;
        end else if (frame_end_i) begin
            pend_q  <= 1'b0;
            fired_q <= fire_now;
            if (fire_now)
                trace_q <= TW'(TRACE_MAX);
            else if (trace_q != '0)
                trace_q <= trace_q - TW'(1);
        end else begin
            pend_q <= fire_now;
        end
    end

    // Saturate the trace to one slot length.
    always_comb begin
        if (int'(trace_q) > int'(SLOT_LEN))
            width_o = WW'(SLOT_LEN);
        else
            width_o = WW'(trace_q);
    end

    assign fired_o = fired_q;
endmodule

// File: rtl/stdp_pwm_tx.sv
// Line encoder: in the plus slot, high for `width` cycles; in the following
// minus slot, the waveform is inverted. An optional slot-0 spike pulse is
// added on the first cycle. Purely combinational from registered state.
module stdp_pwm_tx
    import stdp_pkg::*;
#(
    parameter slot_e       POS_SLOT = SLOT_LTP_POS,
    parameter bit          COMM_EN  = 1'b1,
    parameter int unsigned CW       = 4,
    parameter int unsigned WW       = 5
) (
    input  slot_e         slot_i,
    input  logic [CW-1:0] cyc_i,
    input  logic          fired_i,
    input  logic [WW-1:0] width_i,
    output logic          line_o
);
    localparam logic [2:0] NEG_SLOT = 3'(POS_SLOT) + 3'd1;

    logic pwm_bit;
    logic comm_bit;

    // Pulse-width encoding across the plus/minus slot pair.
    always_comb begin
        pwm_bit = 1'b0;
        if (3'(slot_i) == 3'(POS_SLOT))
            pwm_bit = (WW'(cyc_i) < width_i);
        else if (3'(slot_i) == NEG_SLOT)
            pwm_bit = (WW'(cyc_i) >= width_i);
    end

    generate
        if (COMM_EN) begin : g_comm
            // Single-cycle spike at the start of the communication slot.
            assign comm_bit = fired_i && (slot_i == SLOT_COMM) && (cyc_i == '0);
        end else begin : g_nocomm
            assign comm_bit = 1'b0;
        end
    endgenerate

    assign line_o = pwm_bit | comm_bit;
endmodule

// File: rtl/stdp_width_rx.sv
// Width receiver: counts the high cycles of the incoming line in the plus slot.
// At the end of the next slot, it reports the count if the local neuron fired
// this frame, and 0 otherwise. Holds the report between updates.
module stdp_width_rx
    import stdp_pkg::*;
#(
    parameter slot_e       MEAS_SLOT = SLOT_LTP_POS,
    parameter int unsigned WW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  slot_e         slot_i,
    input  logic          slot_end_i,
    input  logic          line_i,
    input  logic          own_fired_i,
    output logic [WW-1:0] upd_o
);
    localparam logic [2:0] RPT_SLOT = 3'(MEAS_SLOT) + 3'd1;

    logic [WW-1:0] cnt_q;
    logic [WW-1:0] upd_q;

    // Accumulate the high time, then publish and clear at the end of the pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            upd_q <= '0;
        end else if (slot_i == MEAS_SLOT) begin
            cnt_q <= cnt_q + WW'(line_i);
        end else if ((3'(slot_i) == RPT_SLOT) && slot_end_i) begin
            upd_q <= own_fired_i ? cnt_q : '0;
            cnt_q <= '0;
        end
    end

    assign upd_o = upd_q;
endmodule

// File: rtl/stdp_tdm_driver.sv
// Top: a synapse shared in time between spike traffic and learning pulses.
// The pre side sends its spike and potentiation width; the post side sends its
// depression width. Each side decodes the other's width into an update.
// Assumes SLOT_LEN >= 2 and TRACE_MAX >= 1.
module stdp_tdm_driver
    import stdp_pkg::*;
#(
    parameter int unsigned SLOT_LEN  = 16,
    parameter int unsigned TRACE_MAX = 15
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             pre_spike,
    input  logic                             post_spike,
    output logic                             pre_line,
    output logic                             post_line,
    output logic                             comm_spike,
    output logic [2:0]                       slot_idx,
    output logic [$clog2(SLOT_LEN+1)-1:0]    ltp_upd,
    output logic [$clog2(SLOT_LEN+1)-1:0]    ltd_upd
);
    localparam int unsigned CW = $clog2(SLOT_LEN);
    localparam int unsigned TW = $clog2(TRACE_MAX + 1);
    localparam int unsigned WW = $clog2(SLOT_LEN + 1);

    slot_e         slot;
    logic [CW-1:0] cyc;
    logic          slot_end;
    logic          frame_end;
    logic          pre_fired, post_fired;
    logic [WW-1:0] pre_width, post_width;

    stdp_frame_timer #(.SLOT_LEN(SLOT_LEN), .CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .slot_o(slot), .cyc_o(cyc),
        .slot_end_o(slot_end), .frame_end_o(frame_end)
    );

    stdp_trace_unit #(.SLOT_LEN(SLOT_LEN), .TRACE_MAX(TRACE_MAX), .TW(TW), .WW(WW)) u_pre_trace (
        .clk(clk), .rst_n(rst_n), .spike_i(pre_spike), .frame_end_i(frame_end),
        .fired_o(pre_fired), .width_o(pre_width)
    );

    stdp_trace_unit #(.SLOT_LEN(SLOT_LEN), .TRACE_MAX(TRACE_MAX), .TW(TW), .WW(WW)) u_post_trace (
        .clk(clk), .rst_n(rst_n), .spike_i(post_spike), .frame_end_i(frame_end),
        .fired_o(post_fired), .width_o(post_width)
    );

    stdp_pwm_tx #(.POS_SLOT(SLOT_LTP_POS), .COMM_EN(1'b1), .CW(CW), .WW(WW)) u_pre_tx (
        .slot_i(slot), .cyc_i(cyc), .fired_i(pre_fired), .width_i(pre_width), .line_o(pre_line)
    );

    stdp_pwm_tx #(.POS_SLOT(SLOT_LTD_POS), .COMM_EN(1'b0), .CW(CW), .WW(WW)) u_post_tx (
        .slot_i(slot), .cyc_i(cyc), .fired_i(post_fired), .width_i(post_width), .line_o(post_line)
    );

    // Post side decodes the forward width into potentiation.
    stdp_width_rx #(.MEAS_SLOT(SLOT_LTP_POS), .WW(WW)) u_ltp_rx (
        .clk(clk), .rst_n(rst_n), .slot_i(slot), .slot_end_i(slot_end),
        .line_i(pre_line), .own_fired_i(post_fired), .upd_o(ltp_upd)
    );

    // Pre side decodes the backward width into depression.
    stdp_width_rx #(.MEAS_SLOT(SLOT_LTD_POS), .WW(WW)) u_ltd_rx (
        .clk(clk), .rst_n(rst_n), .slot_i(slot), .slot_end_i(slot_end),
        .line_i(post_line), .own_fired_i(pre_fired), .upd_o(ltd_upd)
    );

    // The post neuron receives the forward line during the communication slot.
    assign comm_spike = pre_line && (slot == SLOT_COMM);
    assign slot_idx   = 3'(slot);
endmodule

// File: rtl/stdp_tdm_checker.sv
// Port-level properties of the synapse driver, bound to every instance.
module stdp_tdm_checker #(
    parameter int unsigned SLOT_LEN  = 16,
    parameter int unsigned TRACE_MAX = 15,
    parameter int unsigned WW        = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pre_line,
    input logic          post_line,
    input logic          comm_spike,
    input logic [2:0]    slot_idx,
    input logic [WW-1:0] ltp_upd,
    input logic [WW-1:0] ltd_upd
);
    localparam int unsigned UMAX = (TRACE_MAX < SLOT_LEN) ? TRACE_MAX : SLOT_LEN;

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx <= 3'd4); // R1
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slot_idx) |-> (slot_idx == $past(slot_idx) + 3'd1) || (slot_idx == 3'd0 && $past(slot_idx) == 3'd4)); // R1
    AST_COMM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        comm_spike |=> !comm_spike); // R2
    AST_PRE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx >= 3'd3) |-> !pre_line); // R3
    AST_POST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx <= 3'd2) |-> !post_line); // R4
    AST_LTP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ltp_upd) |-> (slot_idx == 3'd3 && $past(slot_idx) == 3'd2)); // R6
    AST_LTD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ltd_upd) |-> (slot_idx == 3'd0 && $past(slot_idx) == 3'd4)); // R7
    AST_UPD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ltp_upd) <= UMAX) && (int'(ltd_upd) <= UMAX)); // R5
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!pre_line && !post_line && slot_idx == 3'd0 && ltp_upd == '0 && ltd_upd == '0)); // R8
endmodule

bind stdp_tdm_driver stdp_tdm_checker #(
    .SLOT_LEN(SLOT_LEN), .TRACE_MAX(TRACE_MAX), .WW($clog2(SLOT_LEN+1))
) u_tdm_checker (
    .clk(clk), .rst_n(rst_n), .pre_line(pre_line), .post_line(post_line),
    .comm_spike(comm_spike), .slot_idx(slot_idx), .ltp_upd(ltp_upd), .ltd_upd(ltd_upd)
);

// File: tb/stdp_tdm_driver_bench.sv
module stdp_tdm_driver_bench;
    localparam int L    = 16;
    localparam int TMAX = 15;
    localparam int WWB  = $clog2(L + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pre_spike = 1'b0;
    logic post_spike = 1'b0;
    logic pre_line, post_line, comm_spike;
    logic [2:0] slot_idx;
    logic [WWB-1:0] ltp_upd, ltd_upd;

    int n_chk = 0;
    int n_err = 0;
    bit started = 0;

    // behavioural reference state
    int m_slot = 0, m_cyc = 0, frame_no = 0;
    int m_pre_pend = 0, m_pre_fired = 0, m_pre_tr = 0;
    int m_post_pend = 0, m_post_fired = 0, m_post_tr = 0;
    int m_ltp_cnt = 0, m_ltd_cnt = 0, m_ltp = 0, m_ltd = 0;

    always #10 clk = ~clk;

    stdp_tdm_driver #(.SLOT_LEN(L), .TRACE_MAX(TMAX)) u_stdp_tdm_driver (
        .clk(clk), .rst_n(rst_n), .pre_spike(pre_spike), .post_spike(post_spike),
        .pre_line(pre_line), .post_line(post_line), .comm_spike(comm_spike),
        .slot_idx(slot_idx), .ltp_upd(ltp_upd), .ltd_upd(ltd_upd)
    );

    function automatic int wid(int t);
        return (t > L) ? L : t;
    endfunction

    function automatic int exp_pre();
        if (m_slot == 0) return (m_cyc == 0 && m_pre_fired != 0) ? 1 : 0;
        if (m_slot == 1) return (m_cyc < wid(m_pre_tr)) ? 1 : 0;
        if (m_slot == 2) return (m_cyc >= wid(m_pre_tr)) ? 1 : 0;
        return 0;
    endfunction

    function automatic int exp_post();
        if (m_slot == 3) return (m_cyc < wid(m_post_tr)) ? 1 : 0;
        if (m_slot == 4) return (m_cyc >= wid(m_post_tr)) ? 1 : 0;
        return 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_slot = 0; m_cyc = 0; frame_no = 0;
            m_pre_pend = 0; m_pre_fired = 0; m_pre_tr = 0;
            m_post_pend = 0; m_post_fired = 0; m_post_tr = 0;
            m_ltp_cnt = 0; m_ltd_cnt = 0; m_ltp = 0; m_ltd = 0;
        end else begin
            int pl, ql, f;
            pl = exp_pre();
            ql = exp_post();
            if (m_slot == 1) m_ltp_cnt += pl;
            if (m_slot == 2 && m_cyc == L - 1) begin
                m_ltp = (m_post_fired != 0) ? m_ltp_cnt : 0;
                m_ltp_cnt = 0;
            end
            if (m_slot == 3) m_ltd_cnt += ql;
            if (m_slot == 4 && m_cyc == L - 1) begin
                m_ltd = (m_pre_fired != 0) ? m_ltd_cnt : 0;
                m_ltd_cnt = 0;
            end
            if (m_slot == 4 && m_cyc == L - 1) begin
                f = (m_pre_pend != 0 || pre_spike) ? 1 : 0;
                m_pre_fired = f; m_pre_pend = 0;
                m_pre_tr = f ? TMAX : ((m_pre_tr > 0) ? m_pre_tr - 1 : 0);
                f = (m_post_pend != 0 || post_spike) ? 1 : 0;
                m_post_fired = f; m_post_pend = 0;
                m_post_tr = f ? TMAX : ((m_post_tr > 0) ? m_post_tr - 1 : 0);
                frame_no++;
            end else begin
                if (pre_spike) m_pre_pend = 1;
                if (post_spike) m_post_pend = 1;
            end
            if (m_cyc == L - 1) begin
                m_cyc = 0;
                m_slot = (m_slot == 4) ? 0 : m_slot + 1;
            end else begin
                m_cyc++;
            end
        end
    end

    // Every-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R1 slot_idx", int'(slot_idx), m_slot);
            chk("R3 pre_line", int'(pre_line), exp_pre());
            chk("R4 post_line", int'(post_line), exp_post());
            chk("R2 comm_spike", int'(comm_spike), (m_slot == 0) ? exp_pre() : 0);
            chk("R6 ltp_upd", int'(ltp_upd), m_ltp);
            chk("R7 ltd_upd", int'(ltd_upd), m_ltd);
        end
    end

    task automatic wait_at(int f, int s);
        while (!(frame_no == f && m_slot == s && m_cyc == 0)) @(negedge clk);
    endtask

    task automatic pulse(bit do_pre, bit do_post);
        pre_spike = do_pre; post_spike = do_post;
        @(negedge clk);
        pre_spike = 1'b0; post_spike = 1'b0;
    endtask

    task automatic count_high(output int c);
        c = 0;
        repeat (L) begin
            c += int'(pre_line);
            @(negedge clk);
        end
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        chk("R8 reset pre_line", int'(pre_line), 0);
        chk("R8 reset slot_idx", int'(slot_idx), 0);
        rst_n = 1'b1;

        wait_at(0, 1); pulse(1, 0);
        wait_at(1, 1); pulse(0, 1);
        wait_at(2, 3); chk("R6 ltp after pre then post", int'(ltp_upd), 14);
        wait_at(3, 0); chk("R7 ltd without pre fire", int'(ltd_upd), 0);
        wait_at(3, 1); pulse(1, 0);
        wait_at(3, 3); pulse(1, 0);
        wait_at(4, 0); count_high(c); chk("R9 one emission for two spikes", c, 1);
        wait_at(4, 3); chk("R6 ltp without post fire", int'(ltp_upd), 0);
        wait_at(5, 0); chk("R7 ltd after post then pre", int'(ltd_upd), 13);
        wait_at(22, 1); count_high(c); chk("R5 trace decayed to zero", c, 0);
        count_high(c); chk("R10 minus slot fills pair", c, L);
        pulse(0, 1);
        wait_at(23, 3); chk("R6 zero width gives zero", int'(ltp_upd), 0);
        wait_at(24, 4);
        while (m_cyc != L - 1) @(negedge clk);
        pulse(1, 0);
        chk("R2 late spike emitted at slot 0", int'(pre_line), 1);
        @(negedge clk);
        chk("R2 pulse lasts one cycle", int'(pre_line), 0);
        wait_at(25, 1); count_high(c); chk("R3 full trace width", c, TMAX);
        wait_at(26, 1);
        chk("R7 ltd before reset", int'(ltd_upd), 13);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 pre_line", int'(pre_line), 0);
        chk("R8 post_line", int'(post_line), 0);
        chk("R8 slot_idx", int'(slot_idx), 0);
        chk("R8 ltd_upd", int'(ltd_upd), 0);
        rst_n = 1'b1;
        wait_at(0, 2); pulse(1, 1);
        wait_at(1, 3); chk("R6 simultaneous spikes", int'(ltp_upd), TMAX);
        wait_at(2, 0); chk("R7 simultaneous spikes", int'(ltd_upd), TMAX);
        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(20 * 20000);
        n_err++;
        $display("FAIL R1 watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule